// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard controller of an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory access and write-back. It carries only the control fields of each instruction through its own stage registers: valid flag, source and destination register numbers, write enable, load flag and branch kind. It tells the rest of the pipeline three things. The first is which value each ALU operand should take. The second is when fetch and decode must freeze for a cycle. The third is when a branch in decode changes the program counter.

Operands of the instruction in execute are taken from the memory-stage or write-back-stage result when an older instruction there writes the same register. A load followed at once by an instruction that reads its result cannot be covered this way, so the controller holds the program counter and the decode register for one cycle and sends an empty slot into execute.

Branches are decided in decode. An external register read supplies a flag that says whether the tested register is zero. The branch is taken on zero or on non-zero, depending on its kind. A taken branch raises a redirect that is valid in the same cycle. A mode input selects how the instruction fetched behind the branch is treated. In the first mode it is discarded, which models prediction of the fall-through path. In the second mode it is kept and executed as a delay slot.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the valid execute-stage instruction has a non-zero source register equal to the destination of the valid memory-stage instruction, and that instruction has its write enable set, the operand select for that source is 2'b10.
- R2: When only the valid write-back-stage instruction matches, under the same rules, the select is 2'b01. An instruction three or more slots older gives 2'b00, meaning the register file value.
- R3: When both the memory stage and the write-back stage match a source, the memory stage (the younger result) wins with 2'b10. The value 2'b11 never appears.
- R4: Register 0 never matches. A source of 0 gets select 2'b00 even if an older instruction names register 0 as its destination and has its write enable set. A load into register 0 never causes a stall.
- R5: An older instruction with its write enable clear is never a forwarding source.
- R6: A valid load in execute, with its write enable set and a non-zero destination equal to a source of the valid decode instruction, raises stall for exactly one cycle. During that cycle the decode contents are held, the fetch input is not taken, and execute receives an empty slot in the next cycle. The dependent instruction later gets select 2'b01.
- R7: A valid branch in decode is taken when the zero flag is 1 for the equal-to-zero kind (ne=0), or when the flag is 0 for the non-zero kind (ne=1). A taken branch raises redirect in that same cycle. A branch that is not taken leaves redirect low.
- R8: With delay-slot mode off, a taken branch also raises squash, and decode is empty in the next cycle. A branch that is not taken lets the following instruction reach decode.
- R9: With delay-slot mode on, a taken branch raises redirect but not squash. The instruction behind it reaches decode and then execute.
- R10: After reset all stages are empty: id_valid, ex_valid, stall, redirect and squash are 0, and both selects are 2'b00.
- R11: While stall is high, redirect is held low. A branch that waits behind a load resolves in the cycle after the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_delay_slot | input | 1 | 1: instruction after a branch always executes; 0: it is squashed when the branch is taken |
| if_valid | input | 1 | Fetched instruction present |
| if_rs1 | input | RW | First source register of fetched instruction |
| if_rs2 | input | RW | Second source register of fetched instruction |
| if_rd | input | RW | Destination register of fetched instruction |
| if_wen | input | 1 | Fetched instruction writes its destination |
| if_load | input | 1 | Fetched instruction is a load |
| if_branch | input | 1 | Fetched instruction is a conditional branch |
| if_br_ne | input | 1 | Branch kind: 0 taken on zero, 1 taken on non-zero |
| id_cond_zero | input | 1 | Register tested by the decode branch reads as zero |
| fwd_a | output | 2 | Select for first ALU operand: 00 regfile, 10 memory stage, 01 write-back stage |
| fwd_b | output | 2 | Select for second ALU operand, same coding |
| stall | output | 1 | Hold PC and decode register, bubble execute |
| redirect | output | 1 | Taken branch in decode: load branch target into PC |
| squash | output | 1 | Discard the instruction being fetched this cycle |
| id_valid | output | 1 | Decode stage holds a live instruction |
| ex_valid | output | 1 | Execute stage holds a live instruction |

## Verification
The bench places two producers of the same register back to back. A controller that ranks the older result first would hand the consumer a stale value. The bench also has an instruction write register 0 with its write enable set, and another instruction write a register with its write enable clear. A design that skipped the zero or enable gating would forward a value that was never meant to arrive.

A load is followed by a dependent instruction and then by a load into register 0. A missing stall, a stall that lasts two cycles, or a false stall on register 0 each show up as a wrong stall or valid pattern. The bench also sends a branch that depends on a load. This catches a redirect that fires while the pipeline is frozen.

Both branch kinds are run taken and not taken, with the squash mode and the delay-slot mode each in turn. The bench then checks whether the slot behind the branch survives.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_delay_slot,
  input  logic          if_valid,
  input  logic [RW-1:0] if_rs1,
  input  logic [RW-1:0] if_rs2,
  input  logic [RW-1:0] if_rd,
  input  logic          if_wen,
  input  logic          if_load,
  input  logic          if_branch,
  input  logic          if_br_ne,
  input  logic          id_cond_zero,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          redirect,
  output logic          squash,
  output logic          id_valid,
  output logic          ex_valid
);

  typedef struct packed {
    logic          vld;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic [RW-1:0] rd;
    logic          wen;
    logic          ld;
    logic          br;
    logic          ne;
  } slot_t;

  localparam slot_t EMPTY = '0;

  slot_t fetched, ifid, idex, exmem, memwb;

  assign fetched = '{vld: if_valid, rs1: if_rs1, rs2: if_rs2, rd: if_rd,
                     wen: if_wen, ld: if_load, br: if_branch, ne: if_br_ne};

  function automatic logic writes(input slot_t s, input logic [RW-1:0] r);
    return s.vld && s.wen && (s.rd != '0) && (s.rd == r);
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] src, input slot_t m, input slot_t w);
    if (writes(m, src)) return 2'b10;
    if (writes(w, src)) return 2'b01;
    return 2'b00;
  endfunction

  logic taken;

  assign fwd_a = idex.vld ? pick(idex.rs1, exmem, memwb) : 2'b00;
  assign fwd_b = idex.vld ? pick(idex.rs2, exmem, memwb) : 2'b00;

  assign stall = ifid.vld && idex.ld &&
                 (writes(idex, ifid.rs1) || writes(idex, ifid.rs2));

  assign taken    = ifid.ne ? !id_cond_zero : id_cond_zero;
  assign redirect = ifid.vld && ifid.br && taken && !stall;
  assign squash   = redirect && !cfg_delay_slot;

  assign id_valid = ifid.vld;
  assign ex_valid = idex.vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifid  <= EMPTY;
      idex  <= EMPTY;
      exmem <= EMPTY;
      memwb <= EMPTY;
    end else begin
      if (!stall) ifid <= squash ? EMPTY : fetched;
      idex  <= stall ? EMPTY : ifid;
      exmem <= idex;
      memwb <= exmem;
    end
  end

  assert_bubble_after_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid);

  assert_decode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ifid));

  assert_no_load_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b10 || fwd_b == 2'b10) |-> !exmem.ld);

  assert_zero_reg_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b00) |-> (idex.rs1 != '0));

  assert_zero_reg_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b != 2'b00) |-> (idex.rs2 != '0));

  assert_sel_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  assert_squash_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !id_valid);

  assert_delay_slot_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cfg_delay_slot && if_valid) |=> id_valid);

  assert_no_redirect_in_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect);

endmodule

// File: tb/sim_pipe_hazard_ctl.sv
module sim_pipe_hazard_ctl;

  localparam int RW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cfg = 1'b0, cz = 1'b0;
  logic v = 1'b0, we = 1'b0, ld = 1'b0, br = 1'b0, ne = 1'b0;
  logic [RW-1:0] s1 = '0, s2 = '0, d = '0;
  logic [1:0] fwd_a, fwd_b;
  logic stall, redirect, squash, id_valid, ex_valid;

  pipe_hazard_ctl #(.RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_delay_slot(cfg),
    .if_valid(v), .if_rs1(s1), .if_rs2(s2), .if_rd(d),
    .if_wen(we), .if_load(ld), .if_branch(br), .if_br_ne(ne),
    .id_cond_zero(cz),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .redirect(redirect),
    .squash(squash), .id_valid(id_valid), .ex_valid(ex_valid)
  );

  typedef struct packed {
    logic v; logic [RW-1:0] s1, s2, d; logic we, ld, br, ne;
  } ins_t;

  typedef struct {
    logic [1:0] fa, fb;
    logic st, rdr, sq, iv, ev;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic ins_t NOP();
    return '0;
  endfunction
  function automatic ins_t OP(int a, int b, int r, bit w);
    return '{1'b1, RW'(a), RW'(b), RW'(r), w, 1'b0, 1'b0, 1'b0};
  endfunction
  function automatic ins_t LDI(int a, int r);
    return '{1'b1, RW'(a), '0, RW'(r), 1'b1, 1'b1, 1'b0, 1'b0};
  endfunction
  function automatic ins_t BR(int a, bit k);
    return '{1'b1, RW'(a), '0, '0, 1'b0, 1'b0, 1'b1, k};
  endfunction

  task automatic cyc(input ins_t i, input logic z,
                     input logic [1:0] fa, input logic [1:0] fb,
                     input logic st, input logic rdr, input logic sq,
                     input logic iv, input logic ev, input string tag);
    exp_t e;
    @(negedge clk);
    #1;
    {v, s1, s2, d, we, ld, br, ne} = i;
    cz = z;
    e.fa = fa; e.fb = fb; e.st = st; e.rdr = rdr; e.sq = sq;
    e.iv = iv; e.ev = ev; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int expv);
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        cmp(e.tag, "fwd_a", fwd_a, e.fa);
        cmp(e.tag, "fwd_b", fwd_b, e.fb);
        cmp(e.tag, "stall", stall, e.st);
        cmp(e.tag, "redirect", redirect, e.rdr);
        cmp(e.tag, "squash", squash, e.sq);
        cmp(e.tag, "id_valid", id_valid, e.iv);
        cmp(e.tag, "ex_valid", ex_valid, e.ev);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R10");
    cyc(OP(2, 3, 1, 1), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R10");
    // R1 / R2 distance 1, 2, 3
    cyc(OP(1, 3, 4, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R1");
    cyc(OP(1, 1, 6, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R1");
    cyc(OP(9, 1, 8, 1), 0, 2'b10, 2'b00, 0, 0, 0, 1, 1, "R1");
    cyc(NOP(), 0, 2'b01, 2'b01, 0, 0, 0, 1, 1, "R2");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R2");
    // R3 two producers of r5
    cyc(OP(0, 0, 5, 1), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R3");
    cyc(OP(0, 0, 5, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R3");
    cyc(OP(5, 0, 7, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R3");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R3");
    cyc(NOP(), 0, 2'b10, 2'b00, 0, 0, 0, 0, 1, "R3");
    // R4 write to r0, R5 write enable clear
    cyc(OP(3, 4, 0, 1), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R4");
    cyc(OP(1, 1, 3, 0), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R5");
    cyc(OP(0, 3, 9, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R5");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R4");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R4 R5");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R5");
    // R6 load-use
    cyc(LDI(10, 2), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R6");
    cyc(OP(2, 11, 12, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R6");
    cyc(OP(12, 0, 13, 1), 0, 2'b00, 2'b00, 1, 0, 0, 1, 1, "R6");
    cyc(OP(12, 0, 13, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R6");
    cyc(NOP(), 0, 2'b01, 2'b00, 0, 0, 0, 1, 1, "R6");
    cyc(NOP(), 0, 2'b10, 2'b00, 0, 0, 0, 0, 1, "R6");
    // R4 load into r0 must not stall
    cyc(LDI(1, 0), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R4");
    cyc(OP(0, 0, 3, 1), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R4");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R4");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R4");
    // R7 / R8 squash mode
    cyc(BR(5, 0), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R7");
    cyc(OP(0, 0, 14, 1), 1, 2'b00, 2'b00, 0, 1, 1, 1, 0, "R7");
    cyc(OP(0, 0, 15, 1), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R8");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R8");
    cyc(BR(5, 1), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R7");
    cyc(OP(0, 0, 16, 1), 1, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R7");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R8");
    cyc(BR(5, 1), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R7");
    cyc(OP(0, 0, 17, 1), 0, 2'b00, 2'b00, 0, 1, 1, 1, 0, "R7");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R8");
    // R9 delay slot
    cfg = 1'b1;
    cyc(BR(5, 0), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R9");
    cyc(OP(0, 0, 18, 1), 1, 2'b00, 2'b00, 0, 1, 0, 1, 0, "R9");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 1, 1, "R9");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 1, "R9");
    // R11 branch behind a load
    cfg = 1'b0;
    cyc(LDI(1, 6), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R11");
    cyc(BR(6, 0), 0, 2'b00, 2'b00, 0, 0, 0, 1, 0, "R11");
    cyc(OP(0, 0, 19, 1), 1, 2'b00, 2'b00, 1, 0, 0, 1, 1, "R11");
    cyc(OP(0, 0, 19, 1), 1, 2'b00, 2'b00, 0, 1, 1, 1, 0, "R11");
    cyc(NOP(), 0, 2'b01, 2'b00, 0, 0, 0, 0, 1, "R11");
    cyc(NOP(), 0, 2'b00, 2'b00, 0, 0, 0, 0, 0, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule